// File: doc/BRIEF.md
# Multiplexed Output Port Controller

This block decides what appears on a narrow parallel output port. The port can show one of three sources: a live parallel input port, or one of two stored data words (slot A or slot B). The two stored words sit in modelled non-volatile storage. A write to that storage takes a programmable number of clock cycles to land, and an input can block it. A two-bit source code picks the source. It is loaded by serial-bus write requests, but it only reaches the output path when the bus reports a stop condition.

Two pins act on top of the source code. When the active-low override pin is low, every output is forced to zero. When the select pin is high, the output follows the input port whatever the source code says. A separate single-bit side output carries a flag bit stored with each word. This bit passes straight through while the select pin is low. While the pin is high it holds the value it had at the last clock edge before the pin rose.

Top module: `outport_mux_ctrl`

## Requirements
- R1: The active source code `wr_mode` uses these values: 2'b00 shows slot A, 2'b01 shows slot B and 2'b10 shows the input port. A request carrying 2'b11 is ignored entirely, so the earlier selection stays.
- R2: After reset the active code is 2'b10, both slots hold zero, `nv_busy` is 0, `y_out` equals `pin_in` and `side_out` is 0.
- R3: While `ovr_n` is 0, `y_out` and `side_out` are all zero, whatever the other inputs are.
- R4: While `ovr_n` is 1 and `sel_pin` is 1, `y_out` equals `pin_in`.
- R5: While `ovr_n` is 1 and `sel_pin` is 0, `y_out` shows the source chosen by the active code.
- R6: Both slots share one code register. Any accepted request with code 00, 01 or 10 loads that code as the pending selection.
- R7: The pending code becomes active at the clock edge where `bus_stop` is sampled high, and at no other time.
- R8: While `sel_pin` is 0, `side_out` follows the selected flag bit. While `sel_pin` is 1, it holds the value sampled at the last edge with `sel_pin` low.
- R9: A request with `wp` at 1 changes neither slot and does not raise `nv_busy`.
- R10: An accepted slot write (code 00 or 01, `wp` 0, not busy) lands exactly NV_DELAY clock edges after the edge that accepts it.
- R11: `nv_busy` is 1 from the accepting edge until the write lands. A data write that arrives while busy is dropped, but its code is still taken as pending.
- R12: The flag bit comes from slot B when the active code is 01, and from slot A otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | DATA_W | Parallel input port |
| sel_pin | input | 1 | External select: 1 forces the input port onto y_out |
| ovr_n | input | 1 | Active-low override, forces all outputs to 0 |
| wp | input | 1 | Write protect for the stored slots |
| wr_valid | input | 1 | One-cycle write request from the serial side |
| wr_mode | input | 2 | Source code / slot target of the request |
| wr_data | input | DATA_W | Data word for the targeted slot |
| wr_side | input | 1 | Flag bit for the targeted slot |
| bus_stop | input | 1 | One-cycle pulse at a bus stop condition |
| y_out | output | DATA_W | Multiplexed output port |
| side_out | output | 1 | Transparent/held flag output |
| nv_busy | output | 1 | Non-volatile update in progress |

## Verification
The override and select pins act on the outputs in the same cycle, with no register in between. A stop pulse or a request takes effect at the sampling edge, so the result is due just after that edge. A slot write lands exactly NV_DELAY edges after the edge that accepts it. The bench drives inputs on the falling edge and advances one rising edge at a time. Its reference model steps in lockstep, and the outputs are compared on the next falling edge. Directed checks look at the slot contents on both sides of the landing edge. This confirms the delay count exactly, not just as a bound.

// File: rtl/outport_pkg.sv
package outport_pkg;
   typedef enum logic [1:0] {
      SRC_A    = 2'b00,
      SRC_B    = 2'b01,
      SRC_PORT = 2'b10,
      SRC_RSVD = 2'b11
   } src_sel_e;

   localparam int NUM_SLOTS = 2;
endpackage

// File: rtl/outport_mode_ctrl.sv
module outport_mode_ctrl
   import outport_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr_valid,
   input  src_sel_e wr_code,
   input  logic     bus_stop,
   output src_sel_e act_code
);
   src_sel_e pend_code;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_code <= SRC_PORT;
         act_code  <= SRC_PORT;
      end else begin
         if (wr_valid && wr_code != SRC_RSVD)
            pend_code <= wr_code;
         if (bus_stop)
            act_code <= pend_code;
      end
   end

   // R7
   mode_only_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_stop |=> $stable(act_code));

   // R1
   no_rsvd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_code != SRC_RSVD);
endmodule

// File: rtl/outport_nv_store.sv
module outport_nv_store
   import outport_pkg::*;
#(
   parameter int                DATA_W   = 5,
   parameter int                NV_DELAY = 1000,
   parameter logic [DATA_W-1:0] RST_A    = '0,
   parameter logic [DATA_W-1:0] RST_B    = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  src_sel_e          wr_code,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_side,
   input  logic              wp,
   output logic              busy,
   output logic [DATA_W-1:0] data_a,
   output logic [DATA_W-1:0] data_b,
   output logic              side_a,
   output logic              side_b
);
   localparam int CNT_W = $clog2(NV_DELAY + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(NV_DELAY);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

   generate
      if (NV_DELAY < 1) begin : g_bad_delay
         $error("outport_nv_store: NV_DELAY must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0]  cnt;
   logic              tgt;
   logic [DATA_W-1:0] tdata;
   logic              tside;
   logic              accept;
   logic              commit;
   logic [DATA_W-1:0] mem_d [NUM_SLOTS];
   logic              mem_s [NUM_SLOTS];

   assign busy   = (cnt != '0);
   assign commit = (cnt == CNT_LAST);
   assign accept = wr_valid && !wp && !busy &&
                   (wr_code == SRC_A || wr_code == SRC_B);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         tgt   <= 1'b0;
         tdata <= '0;
         tside <= 1'b0;
      end else if (accept) begin
         cnt   <= CNT_LOAD;
         tgt   <= (wr_code == SRC_B);
         tdata <= wr_data;
         tside <= wr_side;
      end else if (busy) begin
         cnt <= cnt - CNT_LAST;
      end
   end

   generate
      for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
         localparam logic [DATA_W-1:0] RST_V = (g == 0) ? RST_A : RST_B;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               mem_d[g] <= RST_V;
               mem_s[g] <= 1'b0;
            end else if (commit && (tgt == g[0])) begin
               mem_d[g] <= tdata;
               mem_s[g] <= tside;
            end
         end
      end
   endgenerate

   assign data_a = mem_d[0];
   assign data_b = mem_d[1];
   assign side_a = mem_s[0];
   assign side_b = mem_s[1];

   // R9
   wp_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && wp && !busy |=> !busy);

   // R11
   busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && wr_valid |=> $stable(tdata) && $stable(tgt) && $stable(tside));

   // R10
   land_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(data_a) && $stable(data_b) && $stable(side_a) && $stable(side_b));
endmodule

// File: rtl/outport_side_latch.sv
module outport_side_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_pin,
   input  logic src_bit,
   output logic side_q
);
   logic hold;

   always_ff @(posedge clk) begin
      if (!rst_n)
         hold <= 1'b0;
      else if (!sel_pin)
         hold <= src_bit;
   end

   assign side_q = sel_pin ? hold : src_bit;

   // R8
   side_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_pin |=> $stable(hold));
endmodule

// File: rtl/outport_mux_ctrl.sv
module outport_mux_ctrl
   import outport_pkg::*;
#(
   parameter int                DATA_W   = 5,
   parameter int                NV_DELAY = 1000,
   parameter logic [DATA_W-1:0] RST_A    = '0,
   parameter logic [DATA_W-1:0] RST_B    = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] pin_in,
   input  logic              sel_pin,
   input  logic              ovr_n,
   input  logic              wp,
   input  logic              wr_valid,
   input  logic [1:0]        wr_mode,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_side,
   input  logic              bus_stop,
   output logic [DATA_W-1:0] y_out,
   output logic              side_out,
   output logic              nv_busy
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("outport_mux_ctrl: DATA_W must be at least 1");
      end
   endgenerate

   src_sel_e          code_in;
   src_sel_e          act_code;
   logic [DATA_W-1:0] data_a, data_b, mux_y;
   logic              side_a, side_b, side_src, side_l;

   assign code_in = src_sel_e'(wr_mode);

   outport_mode_ctrl u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_valid (wr_valid),
      .wr_code  (code_in),
      .bus_stop (bus_stop),
      .act_code (act_code)
   );

   outport_nv_store #(
      .DATA_W   (DATA_W),
      .NV_DELAY (NV_DELAY),
      .RST_A    (RST_A),
      .RST_B    (RST_B)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_valid (wr_valid),
      .wr_code  (code_in),
      .wr_data  (wr_data),
      .wr_side  (wr_side),
      .wp       (wp),
      .busy     (nv_busy),
      .data_a   (data_a),
      .data_b   (data_b),
      .side_a   (side_a),
      .side_b   (side_b)
   );

   assign side_src = (act_code == SRC_B) ? side_b : side_a;

   outport_side_latch u_side (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_pin (sel_pin),
      .src_bit (side_src),
      .side_q  (side_l)
   );

   always_comb begin
      if (sel_pin) begin
         mux_y = pin_in;
      end else begin
         unique case (act_code)
            SRC_A:   mux_y = data_a;
            SRC_B:   mux_y = data_b;
            default: mux_y = pin_in;
         endcase
      end
   end

   assign y_out    = ovr_n ? mux_y  : '0;
   assign side_out = ovr_n ? side_l : 1'b0;

   // R4
   sel_passes_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_n && sel_pin |-> y_out == pin_in);

   // R3
   override_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ovr_n |-> (y_out == '0) && !side_out);
endmodule

// File: tb/sim_outport_mux_ctrl.sv
module sim_outport_mux_ctrl;
   localparam int DW = 5;
   localparam int ND = 12;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst_n = 1'b0;
   logic [DW-1:0] pin_in = '0;
   logic          sel_pin = 1'b0, ovr_n = 1'b1, wp = 1'b0;
   logic          wr_valid = 1'b0, wr_side = 1'b0, bus_stop = 1'b0;
   logic [1:0]    wr_mode = 2'b00;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] y_out;
   logic          side_out, nv_busy;

   outport_mux_ctrl #(.DATA_W(DW), .NV_DELAY(ND)) u0 (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .sel_pin(sel_pin),
      .ovr_n(ovr_n), .wp(wp), .wr_valid(wr_valid), .wr_mode(wr_mode),
      .wr_data(wr_data), .wr_side(wr_side), .bus_stop(bus_stop),
      .y_out(y_out), .side_out(side_out), .nv_busy(nv_busy)
   );

   int checks = 0, errors = 0;
   bit done = 0;

   // reference model state
   logic [1:0]    m_pend, m_act;
   logic [DW-1:0] m_ad, m_bd, m_td;
   logic          m_as, m_bs, m_ts, m_tgt, m_hold;
   int            m_cnt;

   task automatic chk(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   function automatic logic [DW-1:0] exp_y();
      if (!ovr_n) return '0;
      if (sel_pin) return pin_in;
      case (m_act)
         2'b00:   return m_ad;
         2'b01:   return m_bd;
         default: return pin_in;
      endcase
   endfunction

   function automatic logic src_side();
      return (m_act == 2'b01) ? m_bs : m_as;
   endfunction

   function automatic logic exp_side();
      if (!ovr_n) return 1'b0;
      return sel_pin ? m_hold : src_side();
   endfunction

   task automatic model_reset();
      m_pend = 2'b10; m_act = 2'b10; m_ad = '0; m_bd = '0; m_td = '0;
      m_as = 0; m_bs = 0; m_ts = 0; m_tgt = 0; m_hold = 0; m_cnt = 0;
   endtask

   // one rising edge; model and design advance together, then compare
   task automatic tick(input string tag);
      logic [1:0] n_pend = m_pend, n_act = m_act;
      logic n_hold = m_hold;
      if (!sel_pin) n_hold = src_side();
      if (bus_stop) n_act = m_pend;
      if (wr_valid && wr_mode != 2'b11) n_pend = wr_mode;
      if (m_cnt != 0) begin
         if (m_cnt == 1) begin
            if (m_tgt) begin m_bd = m_td; m_bs = m_ts; end
            else       begin m_ad = m_td; m_as = m_ts; end
         end
         m_cnt = m_cnt - 1;
      end else if (wr_valid && !wp && wr_mode[1] == 1'b0) begin
         m_cnt = ND; m_tgt = wr_mode[0]; m_td = wr_data; m_ts = wr_side;
      end
      @(posedge clk);
      m_pend = n_pend; m_act = n_act; m_hold = n_hold;
      @(negedge clk);
      chk({tag, " y_out"}, int'(y_out), int'(exp_y()));
      chk({tag, " side_out"}, int'(side_out), int'(exp_side()));
      chk({tag, " nv_busy"}, int'(nv_busy), int'(m_cnt != 0));
   endtask

   task automatic write(input logic [1:0] md, input logic [DW-1:0] d,
                        input logic s, input string tag);
      wr_valid = 1; wr_mode = md; wr_data = d; wr_side = s;
      tick(tag);
      wr_valid = 0;
   endtask

   task automatic stop(input string tag);
      bus_stop = 1;
      tick(tag);
      bus_stop = 0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got hang expected finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      model_reset();
      pin_in = 5'h0A;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      tick("R2");
      chk("R2 reset y", int'(y_out), 'h0A);
      chk("R2 reset busy", int'(nv_busy), 0);

      ovr_n = 0; pin_in = 5'h1F; sel_pin = 1;
      tick("R3");
      chk("R3 override y", int'(y_out), 0);
      ovr_n = 1; sel_pin = 0;

      write(2'b00, 5'h15, 1'b1, "R6");
      chk("R11 busy after accept", int'(nv_busy), 1);
      tick("R7");
      chk("R7 no stop keeps port", int'(y_out), 'h1F);
      stop("R7");
      chk("R7 slot A before landing", int'(y_out), 0);
      write(2'b01, 5'h0C, 1'b0, "R11");
      for (int i = 0; i < ND - 4; i++) tick("R10");
      chk("R10 one edge before landing", int'(y_out), 0);
      tick("R10");
      chk("R10 landed", int'(y_out), 'h15);
      chk("R10 busy clear", int'(nv_busy), 0);
      stop("R11");
      chk("R11 dropped write B", int'(y_out), 0);
      chk("R12 flag from B", int'(side_out), 0);

      wp = 1;
      write(2'b00, 5'h03, 1'b0, "R9");
      chk("R9 no busy", int'(nv_busy), 0);
      stop("R9");
      for (int i = 0; i < ND + 2; i++) tick("R9");
      chk("R9 slot A kept", int'(y_out), 'h15);
      chk("R12 flag from A", int'(side_out), 1);

      sel_pin = 1; pin_in = 5'h11;
      tick("R4");
      chk("R4 select passes port", int'(y_out), 'h11);
      write(2'b01, 5'h00, 1'b0, "R8");
      stop("R8");
      chk("R8 flag held", int'(side_out), 1);
      sel_pin = 0;
      tick("R8");
      chk("R8 flag transparent", int'(side_out), 0);
      wp = 0;

      write(2'b11, 5'h1E, 1'b1, "R1");
      chk("R1 code 11 no busy", int'(nv_busy), 0);
      stop("R1");
      chk("R1 code 11 keeps B", int'(y_out), 0);
      write(2'b10, 5'h00, 1'b0, "R6");
      stop("R6");
      chk("R1 code 10 shows port", int'(y_out), 'h11);

      for (int i = 0; i < 600; i++) begin
         pin_in   = DW'($urandom);
         if ($urandom_range(0, 7) == 0) sel_pin = ~sel_pin;
         ovr_n    = ($urandom_range(0, 9) != 0);
         wp       = ($urandom_range(0, 3) == 0);
         wr_valid = ($urandom_range(0, 4) == 0);
         wr_mode  = 2'($urandom);
         wr_data  = DW'($urandom);
         wr_side  = 1'($urandom);
         bus_stop = ($urandom_range(0, 5) == 0);
         tick("R5");
         wr_valid = 0; bus_stop = 0;
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule